// File: doc/BRIEF.md
# Cascaded Compare Timer with Toggle Output

The block is a two-stage timer: a 4-bit low stage and an 8-bit high stage. Both stages advance on system clock edges, qualified by a tick enable. The tick comes from one of several sources chosen by software. A nibble-wide write port reaches seven registers: control, mode, output preset, compare mode, the low compare value, and the high compare value, which is written as two nibbles.

The two stages can be combined in three ways:
- They can form one 12-bit compare counter.
- The low stage can act as a compare prescaler that clocks the high stage.
- The high stage can count the selected tick directly, while the low stage either runs or is held at zero.

Compare matches and overflows can toggle an output flip-flop, clear the counter, and raise an interrupt pulse. Mask bits decide which of these each event does. While the timer is stopped, a register write can preset the flip-flop.

The prescaler compare pulse is brought out as a port so that a neighbouring block can use it as a clock enable. No derived clocks are made; every state change happens on `clk`.

Top module: `cascade_cmp_timer`

## Requirements
- R1: After reset, `tog_out`, `irq` and `pre_pulse` are 0. Control (addr 0) and compare mode (addr 3) reset to 0000b. Mode (addr 1) resets to 11b. Preset (addr 2) resets to 1111b. Both compare registers reset to all ones.
- R2: Control bits [3:2] select the tick: 00 = every clock, 01 = `tick_alt`, 10 = `tick_shift`, 11 = no tick. An unselected tick input has no effect.
- R3: While control bit 0 (run) is 0, both stages are held at zero and no event occurs. A restart therefore counts from zero again.
- R4: A control write that sets run from 0 to 1 toggles `tog_out` if bit 1 of the same write is 1. If bit 1 is 0, `tog_out` is left unchanged.
- R5: Mode 11 cascades the stages into a 12-bit counter. The compare value is {high register, low register}, with the low register holding bits 3:0. In this mode `pre_pulse` marks each carry out of the low stage.
- R6: In mode 10, the low stage counts ticks up to the low compare value and then restarts. Each low match gives one `pre_pulse` and one high-stage tick. A low compare value of 0 passes every tick through.
- R7: In mode 01 the prescaler runs and pulses `pre_pulse`, but the high stage counts ticks directly. In mode 00 the low stage is held at zero, `pre_pulse` stays 0, and the high stage counts ticks directly.
- R8: A match happens on a tick at which the counter equals the compare value. If compare-mode bit 1 is set, the counter returns to 0 on that tick. Otherwise it keeps counting and wraps from all ones to 0.
- R9: An overflow is a tick that wraps the counter from all ones to 0. Compare-mode bit 3 makes overflows toggle `tog_out` and makes the overflow the interrupt source. Compare-mode bit 2 makes matches toggle `tog_out`. When bit 3 is 0, the interrupt source is the match.
- R10: `irq` pulses for one cycle, one clock after the source event, and only when compare-mode bit 0 is 1.
- R11: While run is 0, a write to address 2 sets `tog_out` to bit 3 of the written data. While run is 1, such a write is ignored.
- R12: With no mode or compare write after reset, the block runs as a 12-bit counter with compare value 0xFFF.
- R13: A match and an overflow on the same tick, with both toggle bits set, toggle `tog_out` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_alt | input | 1 | One-cycle tick from the other timer |
| tick_shift | input | 1 | One-cycle tick from the serial shift clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 mode, 2 preset, 3 compare mode, 4 low compare, 5/6 high compare low/high nibble) |
| wr_data | input | 4 | Write data |
| tog_out | output | 1 | Toggle flip-flop |
| pre_pulse | output | 1 | Prescaler match or low-stage carry pulse, one cycle |
| irq | output | 1 | Interrupt pulse, one cycle |

## Verification
A counter left at a wrong value shows at the ports as the first `irq` or toggle arriving at the wrong cycle. The first match after start is therefore timed exactly, and the spacing to the next one is counted. A wrong stage coupling, such as compare bits split wrongly or a prescaler that is not cleared, moves the first match by many cycles, within one compare period. A wrong toggle or interrupt source shows within one overflow period, 256 ticks in the 8-bit modes.

// File: rtl/cascade_cmp_timer.sv
module cascade_cmp_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_alt,
  input  logic       tick_shift,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [3:0] wr_data,
  output logic       tog_out,
  output logic       pre_pulse,
  output logic       irq
);
  localparam int LO_W = 4;
  localparam int HI_W = 8;
  localparam int CW   = LO_W + HI_W;

  logic            run_q, tog_start_q;
  logic [1:0]      clk_sel_q, mode_q;
  logic            ovf_tog_q, cmp_tog_q, cmp_rst_q, irq_en_q;
  logic [LO_W-1:0] cmp_lo_q, lo_q;
  logic [HI_W-1:0] cmp_hi_q, hi_q;

  logic tick_sel, tick, wide, pre_run, pre_hit, t8;
  logic match12, match8, cmp_ev, top, stage_tick, ovf_ev, carry12, pre_ev;
  logic wr_ctrl, wr_preset, start_tog, evt_tog;
  logic [CW-1:0] cnt12, cmp12;

  always_comb begin
    case (clk_sel_q)
      2'b00:   tick_sel = 1'b1;
      2'b01:   tick_sel = tick_alt;
      2'b10:   tick_sel = tick_shift;
      default: tick_sel = 1'b0;
    endcase
  end

  assign tick    = run_q & tick_sel;
  assign wide    = (mode_q == 2'b11);
  assign pre_run = ~wide & (mode_q != 2'b00);
  assign cnt12   = {hi_q, lo_q};
  assign cmp12   = {cmp_hi_q, cmp_lo_q};

  assign match12 = tick & wide & (cnt12 == cmp12);
  assign pre_hit = tick & pre_run & (lo_q == cmp_lo_q);
  assign t8      = (mode_q == 2'b10) ? pre_hit : tick;
  assign match8  = t8 & ~wide & (hi_q == cmp_hi_q);

  assign cmp_ev     = wide ? match12 : match8;
  assign top        = wide ? (cnt12 == {CW{1'b1}}) : (hi_q == {HI_W{1'b1}});
  assign stage_tick = wide ? tick : t8;
  assign ovf_ev     = stage_tick & top & ~(cmp_ev & cmp_rst_q);
  assign carry12    = tick & wide & (lo_q == {LO_W{1'b1}}) & ~(match12 & cmp_rst_q);
  assign pre_ev     = wide ? carry12 : pre_hit;

  assign wr_ctrl   = wr_en & (wr_addr == 3'd0);
  assign wr_preset = wr_en & (wr_addr == 3'd2) & ~run_q;
  assign start_tog = wr_ctrl & ~run_q & wr_data[0] & wr_data[1];
  assign evt_tog   = (cmp_tog_q & cmp_ev) | (ovf_tog_q & ovf_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      tog_start_q <= 1'b0;
      clk_sel_q   <= 2'b00;
      mode_q      <= 2'b11;
      ovf_tog_q   <= 1'b0;
      cmp_tog_q   <= 1'b0;
      cmp_rst_q   <= 1'b0;
      irq_en_q    <= 1'b0;
      cmp_lo_q    <= {LO_W{1'b1}};
      cmp_hi_q    <= {HI_W{1'b1}};
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: {clk_sel_q, tog_start_q, run_q} <= wr_data;
        3'd1: mode_q <= wr_data[1:0];
        3'd3: {ovf_tog_q, cmp_tog_q, cmp_rst_q, irq_en_q} <= wr_data;
        3'd4: cmp_lo_q <= wr_data;
        3'd5: cmp_hi_q[3:0] <= wr_data;
        3'd6: cmp_hi_q[7:4] <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (!run_q) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wide) begin
      if (tick) {hi_q, lo_q} <= (match12 & cmp_rst_q) ? '0 : cnt12 + 1'b1;
    end else begin
      if (!pre_run || pre_hit) lo_q <= '0;
      else if (tick)           lo_q <= lo_q + 1'b1;
      if (t8) hi_q <= (match8 & cmp_rst_q) ? '0 : hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_out   <= 1'b0;
      pre_pulse <= 1'b0;
      irq       <= 1'b0;
    end else begin
      pre_pulse <= pre_ev;
      irq       <= irq_en_q & (ovf_tog_q ? ovf_ev : cmp_ev);
      if (wr_preset)                 tog_out <= wr_data[3];
      else if (start_tog || evt_tog) tog_out <= ~tog_out;
    end
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [1:0] clk_sel,
  input logic [1:0] mode,
  input logic       irq_en,
  input logic       start_req,
  input logic       preset_req,
  input logic       preset_bit,
  input logic       tog,
  input logic       irq,
  input logic       pre
);
  // R3
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!irq && !pre));

  // R2
  no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clk_sel == 2'b11) |=> (!irq && !pre));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);

  // R7
  pre_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> !pre);

  // R11
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_req && !run) |=> (tog == $past(preset_bit)));

  // R4
  start_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !run) |=> (tog != $past(tog)));
endmodule

bind cascade_cmp_timer cct_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run_q),
  .clk_sel    (clk_sel_q),
  .mode       (mode_q),
  .irq_en     (irq_en_q),
  .start_req  (wr_en && wr_addr == 3'd0 && wr_data[1:0] == 2'b11),
  .preset_req (wr_en && wr_addr == 3'd2),
  .preset_bit (wr_data[3]),
  .tog        (tog_out),
  .irq        (irq),
  .pre        (pre_pulse)
);

// File: tb/tb_cascade_cmp_timer.sv
`timescale 1ns/1ps
module tb_cascade_cmp_timer;
  logic clk = 0, rst_n = 0, tick_alt = 0, tick_shift = 0, wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic tog_out, pre_pulse, irq;

  int n_chk = 0, n_err = 0;
  int alt_div = 0, shift_div = 0;
  int n_irq, first_irq, last_irq, n_pre, first_pre, n_tog, first_tog;
  bit done = 0;

  cascade_cmp_timer dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; tick_alt = 0; tick_shift = 0; alt_div = 0; shift_div = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_hi(input logic [7:0] v);
    wr(3'd5, v[3:0]);
    wr(3'd6, v[7:4]);
  endtask

  task automatic watch(input int n);
    logic prev;
    prev = tog_out;
    n_irq = 0; first_irq = 0; last_irq = 0; n_pre = 0; first_pre = 0; n_tog = 0; first_tog = 0;
    for (int k = 1; k <= n; k++) begin
      tick_alt   = (alt_div > 0) && (k % alt_div == 0);
      tick_shift = (shift_div > 0) && (k % shift_div == 0);
      @(negedge clk);
      if (irq) begin n_irq++; if (first_irq == 0) first_irq = k; last_irq = k; end
      if (pre_pulse) begin n_pre++; if (first_pre == 0) first_pre = k; end
      if (tog_out != prev) begin n_tog++; if (first_tog == 0) first_tog = k; end
      prev = tog_out;
    end
    tick_alt = 0; tick_shift = 0;
  endtask

  task automatic t_reset_default();
    do_reset();
    chk("R1", "tog_out", tog_out, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "pre_pulse", pre_pulse, 0);
    wr(3'd3, 4'b0001);
    wr(3'd0, 4'b0001);
    watch(4100);
    chk("R12", "first irq at 0xFFF", first_irq, 4096);
    chk("R12", "irq count", n_irq, 1);
    chk("R5", "low-stage carries", n_pre, 256);
    chk("R5", "first carry", first_pre, 16);
  endtask

  task automatic t_clksel();
    do_reset();
    wr(3'd1, 4'b0000);
    set_hi(8'd2);
    wr(3'd3, 4'b0011);
    alt_div = 3;
    wr(3'd0, 4'b0101);
    watch(45);
    chk("R2", "alt first irq", first_irq, 9);
    chk("R2", "alt irq count", n_irq, 5);
    wr(3'd0, 4'b0000);
    alt_div = 1; shift_div = 3;
    wr(3'd0, 4'b1001);
    watch(45);
    chk("R2", "shift first irq", first_irq, 9);
    chk("R2", "shift irq count", n_irq, 5);
    wr(3'd0, 4'b0000);
    alt_div = 1; shift_div = 1;
    wr(3'd0, 4'b1101);
    watch(30);
    chk("R2", "no-clock irq count", n_irq, 0);
    wr(3'd0, 4'b0000);
    alt_div = 0; shift_div = 0;
    wr(3'd0, 4'b0001);
    watch(30);
    chk("R2", "sysclk first irq", first_irq, 3);
    chk("R2", "sysclk irq count", n_irq, 10);
  endtask

  task automatic t_stop_clears();
    do_reset();
    wr(3'd1, 4'b0000);
    set_hi(8'd9);
    wr(3'd3, 4'b0011);
    wr(3'd0, 4'b0001);
    watch(6);
    wr(3'd0, 4'b0000);
    wr(3'd0, 4'b0001);
    watch(20);
    chk("R3", "first irq after restart", first_irq, 10);
  endtask

  task automatic t_start_toggle();
    do_reset();
    wr(3'd0, 4'b1111);
    chk("R4", "toggle on start", tog_out, 1);
    wr(3'd0, 4'b1100);
    wr(3'd0, 4'b1101);
    chk("R4", "no toggle when bit clear", tog_out, 1);
  endtask

  task automatic t_wide();
    do_reset();
    wr(3'd4, 4'h3);
    set_hi(8'h12);
    wr(3'd3, 4'b0111);
    wr(3'd0, 4'b0001);
    watch(600);
    chk("R5", "first 12-bit match", first_irq, 292);
    chk("R5", "12-bit match count", n_irq, 2);
    chk("R5", "toggle count", n_tog, 2);
    chk("R5", "first toggle", first_tog, 292);
  endtask

  task automatic t_prescaler();
    do_reset();
    wr(3'd1, 4'b0010);
    wr(3'd4, 4'd2);
    set_hi(8'd4);
    wr(3'd3, 4'b0111);
    wr(3'd0, 4'b0001);
    watch(40);
    chk("R6", "first prescale pulse", first_pre, 3);
    chk("R6", "prescale pulses", n_pre, 13);
    chk("R6", "first irq", first_irq, 15);
    chk("R6", "irq count", n_irq, 2);
    wr(3'd0, 4'b0000);
    wr(3'd4, 4'd0);
    wr(3'd0, 4'b0001);
    watch(12);
    chk("R6", "bypass first irq", first_irq, 5);
    chk("R6", "bypass pulses", n_pre, 12);
  endtask

  task automatic t_direct_modes();
    do_reset();
    wr(3'd1, 4'b0000);
    wr(3'd4, 4'd2);
    set_hi(8'd4);
    wr(3'd3, 4'b0011);
    wr(3'd0, 4'b0001);
    watch(20);
    chk("R7", "mode 00 no prescale pulse", n_pre, 0);
    chk("R7", "mode 00 first irq", first_irq, 5);
    wr(3'd0, 4'b0000);
    wr(3'd1, 4'b0001);
    wr(3'd0, 4'b0001);
    watch(20);
    chk("R7", "mode 01 first pulse", first_pre, 3);
    chk("R7", "mode 01 pulses", n_pre, 6);
    chk("R7", "mode 01 first irq", first_irq, 5);
  endtask

  task automatic t_free_run();
    do_reset();
    wr(3'd1, 4'b0000);
    set_hi(8'd4);
    wr(3'd3, 4'b0001);
    wr(3'd0, 4'b0001);
    watch(270);
    chk("R8", "free first match", first_irq, 5);
    chk("R8", "free second match", last_irq, 261);
    chk("R8", "free match count", n_irq, 2);
  endtask

  task automatic t_overflow();
    do_reset();
    wr(3'd1, 4'b0000);
    set_hi(8'd4);
    wr(3'd3, 4'b1001);
    wr(3'd0, 4'b0001);
    watch(270);
    chk("R9", "overflow irq cycle", first_irq, 256);
    chk("R9", "overflow irq count", n_irq, 1);
    chk("R9", "overflow toggle count", n_tog, 1);
    chk("R9", "overflow toggle cycle", first_tog, 256);
  endtask

  task automatic t_both_events();
    do_reset();
    wr(3'd1, 4'b0000);
    wr(3'd3, 4'b1100);
    wr(3'd0, 4'b0001);
    watch(260);
    chk("R13", "single toggle", n_tog, 1);
    chk("R13", "toggle cycle", first_tog, 256);
  endtask

  task automatic t_mask();
    do_reset();
    wr(3'd1, 4'b0000);
    set_hi(8'd2);
    wr(3'd3, 4'b0110);
    wr(3'd0, 4'b0001);
    watch(30);
    chk("R10", "masked irq count", n_irq, 0);
    chk("R10", "toggles still occur", n_tog, 10);
  endtask

  task automatic t_preset();
    do_reset();
    wr(3'd2, 4'b1000);
    chk("R11", "preset set", tog_out, 1);
    wr(3'd2, 4'b0000);
    chk("R11", "preset clear", tog_out, 0);
    wr(3'd0, 4'b1101);
    wr(3'd2, 4'b1000);
    @(negedge clk);
    chk("R11", "preset ignored while running", tog_out, 0);
  endtask

  initial begin
    t_reset_default();
    t_clksel();
    t_stop_clears();
    t_start_toggle();
    t_wide();
    t_prescaler();
    t_direct_modes();
    t_free_run();
    t_overflow();
    t_both_events();
    t_mask();
    t_preset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule